// File: doc/BRIEF.md
# Charge Pump Fast-Start Boost Controller

This block decides when a gate-drive charge pump runs in its fast-start boost mode. Boost is a one-shot window of fixed length. Three events open a window: the power-on reset, the pump output dropping below its fault threshold, and a battery undervoltage that lasts long enough. The analog pump, its oscillator and its comparators are not part of this block. They appear only as digital flag inputs.

When a window ends, the controller spends one cycle checking the pump. If the pump is still below its fault threshold, the controller raises a charge pump fault and locks out all further boosts. The lock holds until a clear strobe arrives while the below-threshold flag is low. Clearing the fault re-arms every trigger. All pins are plain level or strobe signals: no data moves through the block, so it has no handshake.

Top module: `cp_boost_ctrl`

## Requirements
- R1: Each boost window holds `boost_en_o` high for exactly `BOOST_CYC` consecutive clock cycles, after which it drops without any input action.
- R2: While `rst_n` is low, `boost_en_o` is high. The cycle in which reset is released is the first of a full boost window. Reset also leaves `cp_fault_o` and `boost_lock_o` low.
- R3: In the idle state, a high `pump_low_i` sampled at a rising edge makes `boost_en_o` high in the cycle after that edge.
- R4: `bat_uv_i` triggers a boost only once it has been high at `UV_CYC` consecutive rising edges. `boost_en_o` then rises one cycle later. A shorter high run triggers nothing.
- R5: A trigger that is present while a window runs neither restarts nor lengthens that window.
- R6: A check cycle follows every window, with `boost_en_o` low. If `pump_low_i` is high in that cycle, `cp_fault_o` and `boost_lock_o` are high from the next cycle on. If it is low, the block returns to idle with both flags low.
- R7: While locked, `boost_en_o` stays low whatever `pump_low_i` and `bat_uv_i` do, and the lock persists when `pump_low_i` falls unless a clear strobe arrives.
- R8: A `fault_clr_i` strobe is accepted only in a cycle where `pump_low_i` is low. Once accepted, `cp_fault_o` and `boost_lock_o` are low in the next cycle and the triggers of R3 and R4 are live again. A strobe given while `pump_low_i` is high changes nothing.
- R9: `cp_fault_o` and `boost_lock_o` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; every timing figure is in these cycles |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| pump_low_i | input | 1 | Comparator flag: pump output below its fault threshold |
| bat_uv_i | input | 1 | Comparator flag: battery below its undervoltage level |
| fault_clr_i | input | 1 | Single-cycle request to clear a charge pump fault |
| boost_en_o | output | 1 | Boost mode enable for the pump |
| cp_fault_o | output | 1 | Charge pump fault flag |
| boost_lock_o | output | 1 | High while further boosts are locked out |

## Verification
`boost_en_o` is decoded from the state register. A pump-low trigger therefore shows up one cycle after the edge that samples it. An undervoltage trigger needs `UV_CYC` edges in the filter plus one more edge in the state machine. The fault and lock flags change one cycle after the check cycle or after an accepted clear. Every input is driven on a falling edge, and each result is read on the falling edge of the cycle in which it is due. Window lengths are measured by counting consecutive falling-edge samples of `boost_en_o`, which tests R1 and R5 together.

// File: rtl/cp_boost_pkg.sv
package cp_boost_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BOOST  = 2'd1,
    ST_CHECK  = 2'd2,
    ST_LOCKED = 2'd3
  } cpb_state_e;
endpackage

// File: rtl/cp_uv_filter.sv
// Persistence filter: output goes high once the flag has been high for
// UV_CYC consecutive edges, and drops as soon as the flag is seen low.
module cp_uv_filter #(
  parameter int UV_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_i,
  output logic persist_o
);
  localparam int W = $clog2(UV_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(UV_CYC);

  logic [W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!uv_i)        run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign persist_o = (run_q == LIMIT);
endmodule

// File: rtl/cp_boost_timer.sv
// Window timer: counts while run_i is high, flags the last cycle of a window.
module cp_boost_timer #(
  parameter int BOOST_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int W = $clog2(BOOST_CYC + 1);
  localparam logic [W-1:0] LAST = W'(BOOST_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cp_boost_fsm.sv
// Sequencing: reset lands in BOOST; IDLE -> BOOST on a trigger;
// BOOST -> CHECK when the window ends; CHECK -> LOCKED or IDLE.
module cp_boost_fsm
  import cp_boost_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pump_low_i,
  input  logic       uv_persist_i,
  input  logic       fault_clr_i,
  input  logic       win_done_i,
  output cpb_state_e state_o,
  output logic       fault_o
);
  cpb_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       clr_ok;

  assign clr_ok = fault_clr_i && !pump_low_i;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE:   if (pump_low_i || uv_persist_i) state_d = ST_BOOST;
      ST_BOOST:  if (win_done_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (pump_low_i) begin
          state_d = ST_LOCKED;
          fault_d = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_LOCKED: begin
        if (clr_ok) begin
          state_d = ST_IDLE;
          fault_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOST;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign state_o = state_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl
  import cp_boost_pkg::*;
#(
  parameter int BOOST_CYC = 64,
  parameter int UV_CYC    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pump_low_i,
  input  logic bat_uv_i,
  input  logic fault_clr_i,
  output logic boost_en_o,
  output logic cp_fault_o,
  output logic boost_lock_o
);
  cpb_state_e state;
  logic       uv_persist;
  logic       win_done;
  logic       in_boost;

  assign in_boost = (state == ST_BOOST);

  cp_uv_filter #(.UV_CYC(UV_CYC)) u_uv (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_i      (bat_uv_i),
    .persist_o (uv_persist)
  );

  cp_boost_timer #(.BOOST_CYC(BOOST_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (in_boost),
    .done_o (win_done)
  );

  cp_boost_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pump_low_i   (pump_low_i),
    .uv_persist_i (uv_persist),
    .fault_clr_i  (fault_clr_i),
    .win_done_i   (win_done),
    .state_o      (state),
    .fault_o      (cp_fault_o)
  );

  assign boost_en_o   = in_boost;
  assign boost_lock_o = (state == ST_LOCKED);
endmodule

// File: rtl/cp_boost_ctrl_chk.sv
module cp_boost_ctrl_chk #(
  parameter int BOOST_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pump_low_i,
  input logic fault_clr_i,
  input logic boost_en_o,
  input logic cp_fault_o,
  input logic boost_lock_o
);
  localparam int W = $clog2(BOOST_CYC + 1) + 1;

  logic [W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (boost_en_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  // R1 / R5: a window ends after exactly BOOST_CYC high cycles
  a_r1_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_en_o) |-> (run_q == W'(BOOST_CYC)));

  // R5: a window never runs past its length
  a_r5_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en_o |-> (run_q < W'(BOOST_CYC)));

  // R6: the check cycle outcome follows the pump flag
  a_r6_check_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_en_o) |=> (cp_fault_o == $past(pump_low_i)));

  // R7: no boost while locked
  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    boost_lock_o |-> !boost_en_o);

  // R8: the fault drops only after an accepted clear
  a_r8_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cp_fault_o) |-> $past(fault_clr_i && !pump_low_i));

  // R9: fault and lock flags agree
  a_r9_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault_o == boost_lock_o);
endmodule

bind cp_boost_ctrl cp_boost_ctrl_chk #(.BOOST_CYC(BOOST_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pump_low_i   (pump_low_i),
  .fault_clr_i  (fault_clr_i),
  .boost_en_o   (boost_en_o),
  .cp_fault_o   (cp_fault_o),
  .boost_lock_o (boost_lock_o)
);

// File: tb/cp_boost_ctrl_test.sv
module cp_boost_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  BOOST_CYC  = 8;
  localparam int  UV_CYC     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pump_low_i = 1'b0;
  logic bat_uv_i = 1'b0;
  logic fault_clr_i = 1'b0;
  logic boost_en_o, cp_fault_o, boost_lock_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_boost_ctrl #(.BOOST_CYC(BOOST_CYC), .UV_CYC(UV_CYC)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pump_low_i   (pump_low_i),
    .bat_uv_i     (bat_uv_i),
    .fault_clr_i  (fault_clr_i),
    .boost_en_o   (boost_en_o),
    .cp_fault_o   (cp_fault_o),
    .boost_lock_o (boost_lock_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts consecutive high samples of boost_en_o, starting with the current one
  task automatic measure(output int n);
    n = 0;
    while (boost_en_o && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int n;
    repeat (3) @(negedge clk);
    chk("R2 boost_en in reset", boost_en_o, 1);
    rst_n = 1'b1;
    chk("R2 boost_en at release", boost_en_o, 1);
    chk("R2 fault after reset", cp_fault_o, 0);
    chk("R2 lock after reset", boost_lock_o, 0);
    measure(n);
    chk("R1 power-on window length", n, BOOST_CYC);
    @(negedge clk);
    chk("R6 no fault when pump ok", cp_fault_o, 0);
    chk("R6 idle after check", boost_en_o, 0);
  endtask

  task automatic t_pump_trigger;
    int n;
    pump_low_i = 1'b1;
    @(negedge clk);
    chk("R3 boost after pump low", boost_en_o, 1);
    pump_low_i = 1'b0;
    measure(n);
    chk("R1 pump-triggered window length", n, BOOST_CYC);
    @(negedge clk);
    chk("R6 pump recovered no fault", cp_fault_o, 0);
  endtask

  task automatic t_lockout;
    int n;
    int highs;
    pump_low_i = 1'b1;
    @(negedge clk);
    measure(n);
    chk("R5 held trigger does not extend", n, BOOST_CYC);
    @(negedge clk);
    chk("R6 fault after failed boost", cp_fault_o, 1);
    chk("R6 lock after failed boost", boost_lock_o, 1);
    bat_uv_i = 1'b1;
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (boost_en_o) highs++;
    end
    chk("R7 no boost while locked", highs, 0);
    bat_uv_i = 1'b0;
    fault_clr_i = 1'b1;
    @(negedge clk);
    fault_clr_i = 1'b0;
    chk("R8 clear ignored with pump low", cp_fault_o, 1);
    pump_low_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 lock persists without clear", boost_lock_o, 1);
    fault_clr_i = 1'b1;
    @(negedge clk);
    fault_clr_i = 1'b0;
    chk("R8 fault cleared", cp_fault_o, 0);
    chk("R8 lock cleared", boost_lock_o, 0);
    pump_low_i = 1'b1;
    @(negedge clk);
    chk("R8 trigger re-armed", boost_en_o, 1);
    pump_low_i = 1'b0;
    measure(n);
    chk("R1 re-armed window length", n, BOOST_CYC);
    @(negedge clk);
  endtask

  task automatic t_uv_short;
    int highs = 0;
    bat_uv_i = 1'b1;
    for (int i = 0; i < UV_CYC - 1; i++) begin
      @(negedge clk);
      if (boost_en_o) highs++;
    end
    bat_uv_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (boost_en_o) highs++;
    end
    chk("R4 short undervoltage ignored", highs, 0);
  endtask

  task automatic t_uv_long;
    int n;
    int highs = 0;
    bat_uv_i = 1'b1;
    for (int i = 0; i < UV_CYC; i++) begin
      @(negedge clk);
      if (boost_en_o) highs++;
    end
    chk("R4 no boost before persistence", highs, 0);
    @(negedge clk);
    chk("R4 boost after persistent undervoltage", boost_en_o, 1);
    bat_uv_i = 1'b0;
    measure(n);
    chk("R1 undervoltage window length", n, BOOST_CYC);
    @(negedge clk);
    chk("R9 flags agree after uv boost", int'(cp_fault_o == boost_lock_o), 1);
  endtask

  initial begin
    t_reset();
    t_pump_trigger();
    t_lockout();
    t_uv_short();
    t_uv_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule